// File: doc/BRIEF.md
# Halt Mode Entry and Wake Controller

This block decides whether a 4-bit core may stop executing, and when and how it restarts. The core raises a halt request together with a 4-bit operand. The controller checks the entry conditions for the selected mode in that cycle. If they hold, the block enters a halted state. If they do not, it reports that the request completed as a no-operation. An operand that names no mode also raises a prohibited-operand flag.

Two halt modes exist. In the timer halt mode, only the 8-bit timer request ends the halt. In the key/interrupt halt mode, either a key input pin or an enabled interrupt request ends it. On wake, the block emits a one-cycle pulse with a select bit. The select bit tells the core to resume at the next instruction or to branch to the interrupt vector.

Pin levels pass through a two-flop synchronizer before they are compared. The CPU writes two configuration registers. One holds per-pin monitor enables. The other holds the port-1 clear-level bits.

The state machine has three states:
- `ST_RUN`
- `ST_HALT_TMR`
- `ST_HALT_KEY`

It has these transitions:
- `ST_RUN` to `ST_HALT_TMR`: a timer-mode request whose entry conditions hold.
- `ST_RUN` to `ST_HALT_KEY`: a key-mode request whose entry conditions hold.
- `ST_HALT_TMR` to `ST_RUN`: the timer request is set.
- `ST_HALT_KEY` to `ST_RUN`: an active monitored key pin or an enabled pending interrupt.
- Self-loops: in every other case, the state holds.

Top module: `halt_ctrl`

## Requirements
- R1: After reset, `halted`, `nop_pulse`, `bad_op`, `wake` and `wake_vector` are all 0, all monitor enables are 0 and all clear-level bits are 0.
- R2: A request with operand 4'b0010 enters timer halt if `tmr_irq` is 0. It does so with `halted` high one cycle after the request. If `tmr_irq` is 1, the request instead gives a one-cycle `nop_pulse` with `bad_op` low.
- R3: A request with operand 4'b1000 enters key/interrupt halt only when two conditions hold. First, no bit of `irq_flag & irq_en` is set. Second, no monitored key pin is active. Otherwise the request gives `nop_pulse`. A pending flag whose enable is clear does not block entry.
- R4: Any other operand gives `nop_pulse` and `bad_op` together for one cycle, and the block stays running.
- R5: `use_wdata` bits [P0_W-1:0] enable port-0 pins. Bits [P0_W+P1_W-1:P0_W] enable port-1 pins. A port-0 pin is active when low. A port-1 pin is active when it equals its clear-level bit. A pin whose enable is 0 is ignored for entry and for wake.
- R6: A pin change takes effect after two synchronizer stages. A key wake pulse appears three clock edges after the pin changes.
- R7: In key/interrupt halt, an active monitored pin wakes the core with `wake_vector` = 0, whatever the states of `mie` and `irq_en`.
- R8: In key/interrupt halt, a pending flag with a clear enable leaves the core halted. In timer halt, key pins and `irq_flag` have no effect.
- R9: In key/interrupt halt, an enabled pending flag wakes the core one cycle later. `wake_vector` equals `mie`.
- R10: In timer halt, `tmr_irq` wakes the core one cycle later. `wake_vector` = `mie & tmr_en`, so a clear timer enable resumes at the next instruction.
- R11: `wake` is a single-cycle pulse. `halted` falls in the same cycle, and it falls only with `wake`.
- R12: A halt request that arrives while halted is ignored.
- R13: If a key pin and an enabled interrupt wake the core in the same cycle, `wake_vector` equals `mie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | One-cycle halt request from the core |
| halt_op | input | 4 | Halt operand |
| p0_pin | input | P0_W | Port-0 key pin levels (active low) |
| p1_pin | input | P1_W | Port-1 key pin levels |
| use_we | input | 1 | Write strobe for the monitor-enable register |
| use_wdata | input | P0_W+P1_W | Monitor-enable write data |
| lvl_we | input | 1 | Write strobe for the clear-level register |
| lvl_wdata | input | P1_W | Port-1 clear-level write data |
| irq_flag | input | IRQ_W | Interrupt request flags |
| irq_en | input | IRQ_W | Individual interrupt enables |
| tmr_irq | input | 1 | 8-bit timer request flag |
| tmr_en | input | 1 | Timer interrupt enable |
| mie | input | 1 | Master interrupt enable |
| halted | output | 1 | Core is halted |
| nop_pulse | output | 1 | Request completed as a no-operation |
| bad_op | output | 1 | Request carried a prohibited operand |
| wake | output | 1 | One-cycle wake pulse |
| wake_vector | output | 1 | 1: branch to the interrupt vector, 0: resume at the next instruction |

## Verification
The bench targets several corner cases, each tied to the fault it would expose:
- **Disabled pending flag.** A flag that is pending but not enabled must neither block entry nor wake the core. A design that ignored the enable mask would turn the halt into a no-operation, or wake early.
- **Disabled timer enable.** A timer wake with the master enable on and the timer enable clear must resume at the next instruction. A design that used only `mie` would branch to the vector instead.
- **Masked pin.** A pin that is held active and then masked must let the halt proceed. Unmasking it must wake the core. The exact three-edge latency through the synchronizer is also checked.
- **Port-1 clear level.** A non-zero clear level is written, and the pin active level must follow it.
- **Simultaneous wake.** A key and an interrupt that wake the core in the same cycle must select the vector.

// File: rtl/halt_ctrl_pkg.sv
package halt_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_HALT_TMR = 2'd1,
        ST_HALT_KEY = 2'd2
    } hstate_t;

    localparam logic [3:0] OP_TMR = 4'b0010;
    localparam logic [3:0] OP_KEY = 4'b1000;

endpackage

// File: rtl/hc_pin_sync.sv
module hc_pin_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Two stages; reset to high so unconfigured lines read as idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '1;
            stage2 <= '1;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/hc_cfg.sv
module hc_cfg #(
    parameter int P0_W = 8,
    parameter int P1_W = 4,
    localparam int USE_W = P0_W + P1_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_we,
    input  logic [USE_W-1:0] use_wdata,
    input  logic             lvl_we,
    input  logic [P1_W-1:0]  lvl_wdata,
    output logic [USE_W-1:0] use_q,
    output logic [P1_W-1:0]  lvl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            use_q <= '0;
            lvl_q <= '0;
        end else begin
            if (use_we) use_q <= use_wdata;
            if (lvl_we) lvl_q <= lvl_wdata;
        end
    end
endmodule

// File: rtl/hc_eval.sv
module hc_eval #(
    parameter int P0_W  = 8,
    parameter int P1_W  = 4,
    parameter int IRQ_W = 3,
    localparam int USE_W = P0_W + P1_W
) (
    input  logic [P0_W-1:0]  p0_s,
    input  logic [P1_W-1:0]  p1_s,
    input  logic [USE_W-1:0] use_q,
    input  logic [P1_W-1:0]  lvl_q,
    input  logic [IRQ_W-1:0] irq_flag,
    input  logic [IRQ_W-1:0] irq_en,
    output logic             key_hit,
    output logic             irq_hit
);
    logic [P0_W-1:0] p0_act;
    logic [P1_W-1:0] p1_act;

    // Port-0 lines: idle high, active low
    for (genvar i = 0; i < P0_W; i++) begin : g_p0
        assign p0_act[i] = use_q[i] & ~p0_s[i];
    end

    // Port-1 lines: active when the line equals its programmed clear level
    for (genvar j = 0; j < P1_W; j++) begin : g_p1
        assign p1_act[j] = use_q[P0_W + j] & ~(p1_s[j] ^ lvl_q[j]);
    end

    assign key_hit = (|p0_act) | (|p1_act);
    assign irq_hit = |(irq_flag & irq_en);
endmodule

// File: rtl/halt_ctrl.sv
module halt_ctrl
    import halt_ctrl_pkg::*;
#(
    parameter int P0_W  = 8,
    parameter int P1_W  = 4,
    parameter int IRQ_W = 3,
    localparam int USE_W = P0_W + P1_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_req,
    input  logic [3:0]       halt_op,
    input  logic [P0_W-1:0]  p0_pin,
    input  logic [P1_W-1:0]  p1_pin,
    input  logic             use_we,
    input  logic [USE_W-1:0] use_wdata,
    input  logic             lvl_we,
    input  logic [P1_W-1:0]  lvl_wdata,
    input  logic [IRQ_W-1:0] irq_flag,
    input  logic [IRQ_W-1:0] irq_en,
    input  logic             tmr_irq,
    input  logic             tmr_en,
    input  logic             mie,
    output logic             halted,
    output logic             nop_pulse,
    output logic             bad_op,
    output logic             wake,
    output logic             wake_vector
);
    logic [P0_W-1:0]  p0_s;
    logic [P1_W-1:0]  p1_s;
    logic [USE_W-1:0] use_q;
    logic [P1_W-1:0]  lvl_q;
    logic             key_hit;
    logic             irq_hit;

    hstate_t state, state_nxt;
    logic    op_legal;
    logic    tmr_ok;
    logic    key_ok;

    hc_pin_sync #(.W(P0_W)) u_sync_p0 (
        .clk(clk), .rst_n(rst_n), .d(p0_pin), .q(p0_s)
    );

    hc_pin_sync #(.W(P1_W)) u_sync_p1 (
        .clk(clk), .rst_n(rst_n), .d(p1_pin), .q(p1_s)
    );

    hc_cfg #(.P0_W(P0_W), .P1_W(P1_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .use_we(use_we), .use_wdata(use_wdata),
        .lvl_we(lvl_we), .lvl_wdata(lvl_wdata),
        .use_q(use_q), .lvl_q(lvl_q)
    );

    hc_eval #(.P0_W(P0_W), .P1_W(P1_W), .IRQ_W(IRQ_W)) u_eval (
        .p0_s(p0_s), .p1_s(p1_s), .use_q(use_q), .lvl_q(lvl_q),
        .irq_flag(irq_flag), .irq_en(irq_en),
        .key_hit(key_hit), .irq_hit(irq_hit)
    );

    assign op_legal = (halt_op == OP_TMR) || (halt_op == OP_KEY);
    assign tmr_ok   = (halt_op == OP_TMR) && !tmr_irq;
    assign key_ok   = (halt_op == OP_KEY) && !irq_hit && !key_hit;

    // Next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: begin
                if (halt_req && tmr_ok)      state_nxt = ST_HALT_TMR;
                else if (halt_req && key_ok) state_nxt = ST_HALT_KEY;
            end
            ST_HALT_TMR: begin
                if (tmr_irq) state_nxt = ST_RUN;
            end
            ST_HALT_KEY: begin
                if (key_hit || irq_hit) state_nxt = ST_RUN;
            end
            default: state_nxt = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    // Registered output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nop_pulse   <= 1'b0;
            bad_op      <= 1'b0;
            wake        <= 1'b0;
            wake_vector <= 1'b0;
        end else begin
            nop_pulse   <= 1'b0;
            bad_op      <= 1'b0;
            wake        <= 1'b0;
            wake_vector <= 1'b0;
            unique case (state)
                ST_RUN: begin
                    if (halt_req && state_nxt == ST_RUN) begin
                        nop_pulse <= 1'b1;
                        bad_op    <= !op_legal;
                    end
                end
                ST_HALT_TMR: begin
                    if (state_nxt == ST_RUN) begin
                        wake        <= 1'b1;
                        wake_vector <= mie & tmr_en;
                    end
                end
                ST_HALT_KEY: begin
                    if (state_nxt == ST_RUN) begin
                        wake        <= 1'b1;
                        wake_vector <= mie & irq_hit;
                    end
                end
                default: ;
            endcase
        end
    end

    assign halted = (state != ST_RUN);
endmodule

// File: rtl/halt_ctrl_chk.sv
module halt_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic halt_req,
    input logic mie,
    input logic halted,
    input logic nop_pulse,
    input logic bad_op,
    input logic wake,
    input logic wake_vector
);
    assert_wake_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    assert_wake_drops_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (!halted && $past(halted)));

    assert_exit_with_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(halted) && !halted) |-> wake);

    assert_bad_is_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |-> nop_pulse);

    assert_nop_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        nop_pulse |-> ($past(halt_req) && !halted));

    assert_entry_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(halt_req));

    assert_vector_needs_mie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_vector |-> (wake && $past(mie)));
endmodule

bind halt_ctrl halt_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .mie(mie),
    .halted(halted), .nop_pulse(nop_pulse), .bad_op(bad_op),
    .wake(wake), .wake_vector(wake_vector)
);

// File: tb/tb_halt_ctrl.sv
`timescale 1ns/1ps
module tb_halt_ctrl;
    localparam int P0_W  = 8;
    localparam int P1_W  = 4;
    localparam int IRQ_W = 3;
    localparam int USE_W = P0_W + P1_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             halt_req = 1'b0;
    logic [3:0]       halt_op = 4'h0;
    logic [P0_W-1:0]  p0_pin = '1;
    logic [P1_W-1:0]  p1_pin = '1;
    logic             use_we = 1'b0;
    logic [USE_W-1:0] use_wdata = '0;
    logic             lvl_we = 1'b0;
    logic [P1_W-1:0]  lvl_wdata = '0;
    logic [IRQ_W-1:0] irq_flag = '0;
    logic [IRQ_W-1:0] irq_en = '0;
    logic             tmr_irq = 1'b0;
    logic             tmr_en = 1'b0;
    logic             mie = 1'b0;
    logic             halted, nop_pulse, bad_op, wake, wake_vector;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    halt_ctrl #(.P0_W(P0_W), .P1_W(P1_W), .IRQ_W(IRQ_W)) dut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .halt_op(halt_op),
        .p0_pin(p0_pin), .p1_pin(p1_pin), .use_we(use_we), .use_wdata(use_wdata),
        .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .irq_flag(irq_flag), .irq_en(irq_en),
        .tmr_irq(tmr_irq), .tmr_en(tmr_en), .mie(mie),
        .halted(halted), .nop_pulse(nop_pulse), .bad_op(bad_op),
        .wake(wake), .wake_vector(wake_vector)
    );

    // Behavioural reference model
    int              m_mode;   // 0 running, 1 timer halt, 2 key halt
    bit              m_nop, m_bad, m_wake, m_vec;
    bit [USE_W-1:0]  m_use;
    bit [P1_W-1:0]   m_lvl;
    bit [P0_W-1:0]   hist0[$];
    bit [P1_W-1:0]   hist1[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_nop = 0; m_bad = 0; m_wake = 0; m_vec = 0;
            m_use = '0; m_lvl = '0;
            hist0 = '{'1, '1};
            hist1 = '{'1, '1};
        end else begin
            bit [P0_W-1:0] seen0;
            bit [P1_W-1:0] seen1;
            bit key, pend;
            seen0 = hist0[0];
            seen1 = hist1[0];
            key = 0;
            for (int i = 0; i < P0_W; i++)
                if (m_use[i] && !seen0[i]) key = 1;
            for (int j = 0; j < P1_W; j++)
                if (m_use[P0_W+j] && seen1[j] == m_lvl[j]) key = 1;
            pend = (irq_flag & irq_en) != 0;
            m_nop = 0; m_bad = 0; m_wake = 0; m_vec = 0;
            if (m_mode == 0) begin
                if (halt_req) begin
                    if (halt_op == 4'd2 && !tmr_irq) m_mode = 1;
                    else if (halt_op == 4'd8 && !pend && !key) m_mode = 2;
                    else begin
                        m_nop = 1;
                        m_bad = (halt_op != 4'd2) && (halt_op != 4'd8);
                    end
                end
            end else if (m_mode == 1) begin
                if (tmr_irq) begin
                    m_wake = 1; m_vec = mie && tmr_en; m_mode = 0;
                end
            end else begin
                if (key || pend) begin
                    m_wake = 1; m_vec = mie && pend; m_mode = 0;
                end
            end
            if (use_we) m_use = use_wdata;
            if (lvl_we) m_lvl = lvl_wdata;
            void'(hist0.pop_front()); hist0.push_back(p0_pin);
            void'(hist1.pop_front()); hist1.push_back(p1_pin);
        end
    end

    // Cycle compare against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [4:0] act, exp;
            act = {halted, nop_pulse, bad_op, wake, wake_vector};
            exp = {m_mode != 0, m_nop, m_bad, m_wake, m_vec};
            checks++;
            if (act !== exp) begin
                fails++;
                $display("FAIL %s model compare: actual=%b expected=%b (halted,nop,bad,wake,vec)",
                         cur_req, act, exp);
            end
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic halt_cmd(logic [3:0] op);
        halt_req = 1'b1;
        halt_op  = op;
        tick(1);
        halt_req = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        tick(3);
        // R1 reset state
        chk("R1", "halted", halted, 1'b0);
        chk("R1", "wake", wake, 1'b0);
        chk("R1", "nop", nop_pulse, 1'b0);
        rst_n = 1'b1;
        tick(1);

        use_we = 1'b1; use_wdata = '1; tick(1); use_we = 1'b0; tick(3);

        cur_req = "R4";
        halt_cmd(4'h5);
        chk("R4", "nop", nop_pulse, 1'b1);
        chk("R4", "bad_op", bad_op, 1'b1);
        chk("R4", "halted", halted, 1'b0);
        tick(1);

        cur_req = "R2";
        tmr_irq = 1'b1;
        halt_cmd(4'h2);
        chk("R2", "nop", nop_pulse, 1'b1);
        chk("R2", "bad_op", bad_op, 1'b0);
        tmr_irq = 1'b0;
        halt_cmd(4'h2);
        chk("R2", "halted", halted, 1'b1);

        cur_req = "R8";
        irq_flag = '1; irq_en = '1; p0_pin[0] = 1'b0;
        tick(6);
        chk("R8", "timer halt holds", halted, 1'b1);

        cur_req = "R12";
        halt_cmd(4'h5);
        chk("R12", "bad_op", bad_op, 1'b0);
        chk("R12", "halted", halted, 1'b1);
        irq_flag = '0; irq_en = '0; p0_pin = '1;
        tick(4);

        cur_req = "R10";
        mie = 1'b1; tmr_en = 1'b0; tmr_irq = 1'b1;
        tick(1);
        chk("R10", "wake", wake, 1'b1);
        chk("R10", "vector", wake_vector, 1'b0);
        chk("R11", "halted clears", halted, 1'b0);
        tmr_irq = 1'b0;
        tick(1);
        chk("R11", "single pulse", wake, 1'b0);
        halt_cmd(4'h2);
        tmr_en = 1'b1; tmr_irq = 1'b1;
        tick(1);
        chk("R10", "vector", wake_vector, 1'b1);
        tmr_irq = 1'b0; mie = 1'b0; tmr_en = 1'b0;
        tick(1);

        cur_req = "R3";
        irq_flag = 3'b010; irq_en = 3'b010;
        halt_cmd(4'h8);
        chk("R3", "nop", nop_pulse, 1'b1);
        irq_en = 3'b000;
        halt_cmd(4'h8);
        chk("R3", "halted", halted, 1'b1);
        tick(3);
        chk("R8", "disabled flag holds", halted, 1'b1);

        cur_req = "R9";
        irq_en = 3'b010;
        tick(1);
        chk("R9", "wake", wake, 1'b1);
        chk("R9", "vector", wake_vector, 1'b0);
        irq_flag = '0; irq_en = '0;
        tick(1);

        cur_req = "R5";
        p0_pin[3] = 1'b0;
        tick(3);
        halt_cmd(4'h8);
        chk("R3", "key blocks entry", nop_pulse, 1'b1);
        use_we = 1'b1; use_wdata = '1; use_wdata[3] = 1'b0;
        tick(1); use_we = 1'b0;
        halt_cmd(4'h8);
        chk("R5", "masked pin allows entry", halted, 1'b1);
        tick(4);
        chk("R5", "masked pin no wake", halted, 1'b1);

        cur_req = "R7";
        mie = 1'b1; irq_en = '1;
        use_we = 1'b1; use_wdata = '1;
        tick(1); use_we = 1'b0;
        tick(1);
        chk("R7", "wake", wake, 1'b1);
        chk("R7", "vector", wake_vector, 1'b0);
        p0_pin = '1; irq_en = '0;
        tick(3);

        cur_req = "R9";
        halt_cmd(4'h8);
        irq_en[0] = 1'b1; irq_flag[0] = 1'b1;
        tick(1);
        chk("R9", "vector", wake_vector, 1'b1);
        irq_flag = '0; irq_en = '0; mie = 1'b0;
        tick(1);

        cur_req = "R5";
        lvl_we = 1'b1; lvl_wdata = 4'b0101; p1_pin = 4'b1010;
        tick(1); lvl_we = 1'b0;
        tick(3);
        halt_cmd(4'h8);
        chk("R5", "port1 idle allows entry", halted, 1'b1);

        cur_req = "R6";
        p1_pin = 4'b1011;
        tick(2);
        chk("R6", "no early wake", wake, 1'b0);
        tick(1);
        chk("R6", "wake on third edge", wake, 1'b1);
        chk("R6", "vector", wake_vector, 1'b0);
        p1_pin = 4'b1010;
        tick(3);

        cur_req = "R13";
        mie = 1'b1; irq_en = 3'b100;
        halt_cmd(4'h8);
        p0_pin[0] = 1'b0;
        tick(2);
        chk("R13", "still halted", halted, 1'b1);
        irq_flag = 3'b100;
        tick(1);
        chk("R13", "wake", wake, 1'b1);
        chk("R13", "vector", wake_vector, 1'b1);
        irq_flag = '0; p0_pin = '1;
        tick(3);

        finish_run();
    end
endmodule